// File: doc/BRIEF.md
# Serial volume command decoder

This block turns a stream of ASCII bytes from a UART receiver into six gain settings for an audio mixing path. Each text line has the form `<channel>:<volume>` in decimal and ends with a carriage return or a line feed. The block parses the two numbers and clamps them. It converts the volume to a Q1.15 gain with a square law and writes that gain into the level register the channel selects. It also drives a six-bit LED bar that shows the last volume written.

Gains change only when a complete, well-formed line ends. Between commands the datapath sees stable values. Each write replaces one whole 16-bit register in a single clock edge.

Top module: `vol_cmd_decoder`

## Requirements
- R1: A line is the channel digits, a colon (0x3A), then the volume digits, ended by CR (0x0D) or LF (0x0A). The gain register is written at the clock edge that accepts the terminator byte.
- R2: A clamped channel of 0 selects gain_master, 1 gain_front_l, 2 gain_front_r, 3 gain_rear_l, 4 gain_rear_r and 5 gain_sub.
- R3: A channel above 5 is treated as 5 and a volume above 50 as 50. A number longer than three digits saturates to 999 before the clamp.
- R4: A minus sign (0x2D) placed directly before either number's digits makes that number 0.
- R5: A volume v below 50 gives the gain floor(v*v*32768/2500). A volume of 50 gives 0x7FFF.
- R6: After reset, gain_master is 0x0CCD, the other five gains are 0x7FFF and led_bar is 6'b111111.
- R7: On each write, led_bar becomes ((1<<n)-1)<<1 with n = floor(v/10), so bit 0 stays dark.
- R8: Spaces before the channel number are ignored. A line that has no colon, no channel digits or no volume digits is discarded with no register or LED change. The same applies to a line holding any other unexpected byte.
- R9: At most one gain register changes per clock. No output changes on a clock where no terminator byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | rx_data holds a received byte this cycle |
| rx_data | input | 8 | Received ASCII byte |
| gain_master | output | 16 | Master gain, Q1.15 |
| gain_front_l | output | 16 | Front-left level, Q1.15 |
| gain_front_r | output | 16 | Front-right level, Q1.15 |
| gain_rear_l | output | 16 | Rear-left level, Q1.15 |
| gain_rear_r | output | 16 | Rear-right level, Q1.15 |
| gain_sub | output | 16 | Subwoofer level, Q1.15 |
| led_bar | output | 6 | Bar graph of the last volume |

## Verification
The hardest cases are the lines that must leave every register alone: a missing colon, an empty volume field, or a stray character after valid digits. In each of these cases the correct design shows no change at its ports at all. The stimulus therefore first writes a volume that lights several LEDs and sets a distinctive gain. It then sends each malformed line, so that any partial commit would change a value the monitor can see. Saturating five-digit numbers and minus signs before either field are sent the same way, and each is checked against the clamped value.

// File: rtl/vol_cmd_decoder.sv
module vol_cmd_decoder #(
  parameter int unsigned NUM_MAX   = 999,
  parameter int unsigned CH_MAX    = 5,
  parameter int unsigned VOL_MAX   = 50,
  parameter logic [15:0] MASTER_RST = 16'h0CCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic [15:0] gain_master,
  output logic [15:0] gain_front_l,
  output logic [15:0] gain_front_r,
  output logic [15:0] gain_rear_l,
  output logic [15:0] gain_rear_r,
  output logic [15:0] gain_sub,
  output logic [5:0]  led_bar
);
  localparam int unsigned NLVL = CH_MAX + 1;
  localparam logic [9:0]  SAT  = 10'(NUM_MAX);
  localparam logic [9:0]  SATG = 10'(NUM_MAX / 10);

  typedef enum logic {PH_CH, PH_VOL} phase_t;

  phase_t     phase;
  logic       bad, start;
  logic       ch_neg, ch_any, v_neg, v_any;
  logic [9:0] ch_acc, v_acc;
  logic [15:0] lvl [NLVL];

  wire is_dig  = rx_data >= 8'h30 && rx_data <= 8'h39;
  wire is_term = rx_data == 8'h0D || rx_data == 8'h0A;
  wire is_sp   = rx_data == 8'h20;
  wire is_neg  = rx_data == 8'h2D;
  wire is_col  = rx_data == 8'h3A;

  function automatic logic [9:0] push(input logic [9:0] a, input logic [7:0] c);
    return (a >= SATG) ? SAT : 10'(a * 10'd10 + 10'(c - 8'h30));
  endfunction

  logic [2:0]  ch_c;
  logic [5:0]  vol_c;
  logic [15:0] gain_w;
  logic [2:0]  cnt;
  logic [5:0]  led_w;

  always_comb begin
    ch_c   = ch_neg ? 3'd0 : (ch_acc > 10'(CH_MAX) ? 3'(CH_MAX) : ch_acc[2:0]);
    vol_c  = v_neg ? 6'd0 : (v_acc > 10'(VOL_MAX) ? 6'(VOL_MAX) : v_acc[5:0]);
    gain_w = (vol_c == 6'(VOL_MAX)) ? 16'h7FFF
           : 16'((27'(vol_c) * 27'(vol_c) * 27'd32768) / 27'(VOL_MAX * VOL_MAX));
    cnt    = 3'(vol_c / 6'd10);
    led_w  = 6'(((7'd1 << cnt) - 7'd1) << 1);
  end

  wire commit = rx_valid && is_term && phase == PH_VOL && v_any && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_CH; bad <= 1'b0; start <= 1'b1;
      ch_neg <= 1'b0; ch_any <= 1'b0; ch_acc <= '0;
      v_neg <= 1'b0; v_any <= 1'b0; v_acc <= '0;
      led_bar <= '1;
    end else if (rx_valid) begin
      if (is_term) begin
        phase <= PH_CH; bad <= 1'b0; start <= 1'b1;
        ch_neg <= 1'b0; ch_any <= 1'b0; ch_acc <= '0;
        v_neg <= 1'b0; v_any <= 1'b0; v_acc <= '0;
        if (commit) led_bar <= led_w;
      end else if (!bad) begin
        if (phase == PH_CH) begin
          if (is_sp && start) begin
          end else if (is_neg && start) begin
            ch_neg <= 1'b1; start <= 1'b0;
          end else if (is_dig) begin
            ch_acc <= push(ch_acc, rx_data); ch_any <= 1'b1; start <= 1'b0;
          end else if (is_col && ch_any) begin
            phase <= PH_VOL; start <= 1'b1;
          end else bad <= 1'b1;
        end else begin
          if (is_neg && start) begin
            v_neg <= 1'b1; start <= 1'b0;
          end else if (is_dig) begin
            v_acc <= push(v_acc, rx_data); v_any <= 1'b1; start <= 1'b0;
          end else bad <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) lvl[i] <= (i == 0) ? MASTER_RST : 16'h7FFF;
      else if (commit && ch_c == 3'(i)) lvl[i] <= gain_w;
    end
  end

  assign gain_master  = lvl[0];
  assign gain_front_l = lvl[1];
  assign gain_front_r = lvl[2];
  assign gain_rear_l  = lvl[3];
  assign gain_rear_r  = lvl[4];
  assign gain_sub     = lvl[5];
endmodule

module vol_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic [15:0] gain_master,
  input logic [15:0] gain_front_l,
  input logic [15:0] gain_front_r,
  input logic [15:0] gain_rear_l,
  input logic [15:0] gain_rear_r,
  input logic [15:0] gain_sub,
  input logic [5:0]  led_bar
);
  wire term = rx_valid && (rx_data == 8'h0D || rx_data == 8'h0A);
  wire [101:0] all_out = {led_bar, gain_sub, gain_rear_r, gain_rear_l,
                          gain_front_r, gain_front_l, gain_master};

  assert_quiet_between_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(all_out));

  assert_one_register_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gain_master != $past(gain_master), gain_front_l != $past(gain_front_l),
                gain_front_r != $past(gain_front_r), gain_rear_l != $past(gain_rear_l),
                gain_rear_r != $past(gain_rear_r), gain_sub != $past(gain_sub)}) <= 1);

  assert_led_bit0_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_bar) |-> led_bar[0] == 1'b0);

  assert_led_bar_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_bar) |-> (led_bar[5:1] & (led_bar[5:1] + 5'd1)) == 5'd0);

  assert_gain_full_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_master[15] && !gain_front_l[15] && !gain_front_r[15] &&
    !gain_rear_l[15] && !gain_rear_r[15] && !gain_sub[15]);
endmodule

bind vol_cmd_decoder vol_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .gain_master(gain_master), .gain_front_l(gain_front_l), .gain_front_r(gain_front_r),
  .gain_rear_l(gain_rear_l), .gain_rear_r(gain_rear_r), .gain_sub(gain_sub),
  .led_bar(led_bar)
);

// File: tb/tb_vol_cmd_decoder.sv
module tb_vol_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [15:0] gain_master, gain_front_l, gain_front_r, gain_rear_l, gain_rear_r, gain_sub;
  logic [5:0] led_bar;

  always #4 clk = ~clk;

  vol_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .gain_master(gain_master), .gain_front_l(gain_front_l), .gain_front_r(gain_front_r),
    .gain_rear_l(gain_rear_l), .gain_rear_r(gain_rear_r), .gain_sub(gain_sub),
    .led_bar(led_bar)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_g [6];
  logic [5:0]  m_led;
  logic [101:0] exp_q [$];
  string        tag_q [$];

  function automatic logic [15:0] gain_of(int v);
    if (v == 50) return 16'h7FFF;
    return 16'((v * v * 32768) / 2500);
  endfunction

  function automatic logic [101:0] snap();
    return {m_led, m_g[5], m_g[4], m_g[3], m_g[2], m_g[1], m_g[0]};
  endfunction

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
  endtask

  // ch < 0: line must be discarded
  task automatic cmd(string s, int ch, int vol, string tag);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h00;
    if (ch >= 0) begin
      m_g[ch] = gain_of(vol);
      m_led   = 6'(((1 << (vol / 10)) - 1) << 1);
    end
    exp_q.push_back(snap());
    tag_q.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [101:0] e, a;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {led_bar, gain_sub, gain_rear_r, gain_rear_l, gain_front_r, gain_front_l, gain_master};
        for (int k = 0; k < 6; k++) begin
          checks++;
          if (a[k*16 +: 16] !== e[k*16 +: 16]) begin
            fails++;
            $display("FAIL %s gain%0d actual %h expected %h", t, k, a[k*16 +: 16], e[k*16 +: 16]);
          end
        end
        checks++;
        if (a[101:96] !== e[101:96]) begin
          fails++;
          $display("FAIL %s led actual %b expected %b", t, a[101:96], e[101:96]);
        end
      end
    end
  end

  initial begin
    m_g[0] = 16'h0CCD;
    for (int k = 1; k < 6; k++) m_g[k] = 16'h7FFF;
    m_led = 6'b111111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(snap()); tag_q.push_back("R6 reset");
    repeat (2) @(negedge clk);

    cmd("1:50\n",      1, 50, "R5 R2 full scale front_l");
    cmd("0:25\r",      0, 25, "R1 R2 master CR");
    cmd("2:10\n",      2, 10, "R5 R7 front_r");
    cmd("3:0\n",       3, 0,  "R5 R7 rear_l zero");
    cmd("4:49\n",      4, 49, "R5 R7 rear_r 49");
    cmd("1 30\n",     -1, 0,  "R8 no colon");
    cmd("1:\n",       -1, 0,  "R8 no volume digits");
    cmd(":5\n",       -1, 0,  "R8 no channel digits");
    cmd("1:2x\n",     -1, 0,  "R8 stray byte");
    cmd("\n",         -1, 0,  "R8 empty line");
    cmd("5:1\r\n",     5, 1,  "R2 R1 sub CRLF");
    cmd("9:20\n",      5, 20, "R3 channel clamp");
    cmd("1:75\n",      1, 50, "R3 volume clamp");
    cmd("2:12345\n",   2, 50, "R3 digit saturation");
    cmd("  3:7\n",     3, 7,  "R8 leading spaces");
    cmd("-4:30\n",     0, 30, "R4 negative channel");
    cmd("4:-30\n",     4, 0,  "R4 negative volume");
    cmd("3:33\n",      3, 33, "R9 R5 rear_l again");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule